// File: doc/BRIEF.md
# Memory ECC Error Injection Unit

This block sits in the write path of an ECC memory controller, between the check-bit generator and the command queue. Its job is to corrupt stored check information on purpose, so that the error-reporting logic further along can be tested. Software programs an address pattern through a small register port. Each of the six address fields (dimm within its channel, rank, channel, bank, page and column) can hold a value or be marked as a wildcard. Software also programs a check-bit mask, a half-select and an injection kind, and then arms the unit. When a write whose address fits the pattern passes through, the unit flips the selected check bits and/or the write's parity bit. Every other write passes unchanged.

The write path is a valid/ready stream with no storage. The output is offered whenever the input is offered (`out_valid` follows `in_valid`), and the input is accepted exactly when the downstream is ready (`in_ready` follows `out_ready`). A transfer takes place in a cycle where both `in_valid` and `out_ready` are high. While the downstream stalls, the upstream must hold its request stable. Arming state and the injection count change only on a completed transfer.

Top module: `ecc_inj_unit`

## Requirements
- R1: After reset, every register reads as follows. The six match registers read with the wildcard flag (bit 31) set and value 0. The mask, half-select, kind, arm and count registers all read 0.
- R2: The register map is: match registers dimm=0, rank=1, channel=2, bank=3, page=4, column=5, each holding its value in bits [W-1:0] and the wildcard flag in bit 31; mask=6, in bits [CHK_W-1:0]; half-select=7, in bits [1:0]; kind=8, in bits [2:0]; arm=9, in bit 0; count=10, in bits [CNT_W-1:0], read-only. Every register reads back what was written, truncated to its field width. Unmapped addresses read 0.
- R3: A write is injected only under all of these conditions: the unit is armed, the kind has bit 1 or bit 2 set, and every match field is either a wildcard or equal to the write's field. A wildcard field matches every value.
- R4: When kind bit 1 (ECC) is set, an injected write leaves with its check bits XORed with the mask, restricted to the selected halves. Half-select bit 0 selects the lower half (bits [CHK_W/2-1:0]) and bit 1 selects the upper half, so values 1, 2 and 3 give lower, upper and both. Value 0 gives neither.
- R5: When kind bit 2 (parity) is set, an injected write leaves with its parity bit inverted. If bit 1 is clear, the check bits are not changed.
- R6: A write that is not injected leaves with its check bits and parity unchanged, in the same cycle, and with `out_injected` low. The stream flags are passed straight through.
- R7: Writing a nonzero value to the arm register arms the unit, and writing zero disarms it.
- R8: When kind bit 0 (repeat) is clear, the unit disarms itself after its first injected transfer. Later matching writes then pass unchanged.
- R9: When kind bit 0 is set, every matching transfer is injected and the unit stays armed until software disarms it.
- R10: The count increments on each injected transfer and saturates at its all-ones value. Any write to the arm register clears the count.
- R11: An injected write offered while `out_ready` is low neither counts nor disarms the unit. The write is corrupted when it is finally accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| in_valid | input | 1 | Write request offered |
| in_ready | output | 1 | Write request accepted |
| in_dimm | input | DIMM_W | Dimm within its channel |
| in_rank | input | RANK_W | Rank |
| in_chan | input | CHAN_W | Channel |
| in_bank | input | BANK_W | Bank |
| in_page | input | PAGE_W | Page (row) |
| in_col | input | COL_W | Column |
| in_chk | input | CHK_W | Computed check bits |
| in_par | input | 1 | Computed write parity |
| out_valid | output | 1 | Request offered downstream |
| out_ready | input | 1 | Downstream accepts |
| out_chk | output | CHK_W | Possibly corrupted check bits |
| out_par | output | 1 | Possibly corrupted parity |
| out_injected | output | 1 | This offered write is being corrupted |

## Verification
The bench keeps the default address widths (dimm 1 bit, page 12 bits, column 10 bits, 8 check bits) and narrows the count to 3 bits. With a 3-bit count, saturation at 7 is reached after a handful of repeat-mode transfers. The 1-bit dimm field lets a too-wide write show truncation on readback. The 8-bit check word splits into two 4-bit halves, so each half-select value gives a distinct, easily predicted result. These settings also bring within reach the one-shot behaviour under a downstream stall and the mismatch on a single non-wildcard field.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  localparam int CFG_DW     = 32;
  localparam int CFG_AW     = 4;
  localparam int NUM_FIELDS = 6;
  localparam int WILD_BIT   = 31;

  localparam logic [CFG_AW-1:0] RA_DIMM = 4'd0;
  localparam logic [CFG_AW-1:0] RA_RANK = 4'd1;
  localparam logic [CFG_AW-1:0] RA_CHAN = 4'd2;
  localparam logic [CFG_AW-1:0] RA_BANK = 4'd3;
  localparam logic [CFG_AW-1:0] RA_PAGE = 4'd4;
  localparam logic [CFG_AW-1:0] RA_COL  = 4'd5;
  localparam logic [CFG_AW-1:0] RA_MASK = 4'd6;
  localparam logic [CFG_AW-1:0] RA_HALF = 4'd7;
  localparam logic [CFG_AW-1:0] RA_KIND = 4'd8;
  localparam logic [CFG_AW-1:0] RA_ARM  = 4'd9;
  localparam logic [CFG_AW-1:0] RA_CNT  = 4'd10;

  // injection kind: bit0 repeat, bit1 check-bit flip, bit2 parity flip
  typedef struct packed {
    logic par;
    logic ecc;
    logic rpt;
  } kind_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ecc_inj_field_cmp.sv
module ecc_inj_field_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] want,
  input  logic         wild,
  input  logic [W-1:0] got,
  output logic         hit
);
  assign hit = wild | (want == got);
endmodule

// File: rtl/ecc_inj_cfg.sv
module ecc_inj_cfg import ecc_inj_pkg::*; #(
  parameter int MAX_W = 12,
  parameter int FW0 = 1,
  parameter int FW1 = 2,
  parameter int FW2 = 2,
  parameter int FW3 = 3,
  parameter int FW4 = 12,
  parameter int FW5 = 10,
  parameter int CHK_W = 8,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              xfer_inj,
  output logic [MAX_W-1:0]  fval [NUM_FIELDS],
  output logic [NUM_FIELDS-1:0] fwild,
  output logic [CHK_W-1:0]  mask,
  output logic [1:0]        half,
  output kind_t             kind,
  output logic              armed
);
  localparam int FW [NUM_FIELDS] = '{FW0, FW1, FW2, FW3, FW4, FW5};
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CHK_W-1:0] mask_q;
  logic [1:0]       half_q;
  kind_t            kind_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             arm_wr;
  logic             unused_wdata;

  assign arm_wr       = cfg_we && (cfg_addr == RA_ARM);
  assign unused_wdata = ^cfg_wdata;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [MAX_W-1:0] VMASK = {MAX_W{1'b1}} >> (MAX_W - FW[i]);
    logic [MAX_W-1:0] v_q;
    logic             w_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= '0;
        w_q <= 1'b1;
      end else if (cfg_we && (cfg_addr == CFG_AW'(i))) begin
        v_q <= cfg_wdata[MAX_W-1:0] & VMASK;
        w_q <= cfg_wdata[WILD_BIT];
      end
    end
    assign fval[i]  = v_q;
    assign fwild[i] = w_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      half_q <= '0;
      kind_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == RA_MASK) mask_q <= cfg_wdata[CHK_W-1:0];
      if (cfg_addr == RA_HALF) half_q <= cfg_wdata[1:0];
      if (cfg_addr == RA_KIND) kind_q <= cfg_wdata[2:0];
    end
  end

  // software arm/disarm wins over a same-cycle injection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (arm_wr) begin
      armed_q <= |cfg_wdata;
      cnt_q   <= '0;
    end else if (xfer_inj) begin
      if (!kind_q.rpt) armed_q <= 1'b0;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (cfg_addr == CFG_AW'(i)) begin
        cfg_rdata[MAX_W-1:0] = fval[i];
        cfg_rdata[WILD_BIT]  = fwild[i];
      end
    end
    case (cfg_addr)
      RA_MASK: cfg_rdata[CHK_W-1:0] = mask_q;
      RA_HALF: cfg_rdata[1:0]       = half_q;
      RA_KIND: cfg_rdata[2:0]       = kind_q;
      RA_ARM:  cfg_rdata[0]         = armed_q;
      RA_CNT:  cfg_rdata[CNT_W-1:0] = cnt_q;
      default: ;
    endcase
  end

  assign mask  = mask_q;
  assign half  = half_q;
  assign kind  = kind_q;
  assign armed = armed_q;

  assert_oneshot_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_inj && !kind_q.rpt && !arm_wr) |=> !armed_q);
  assert_repeat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_inj && kind_q.rpt && !arm_wr) |=> armed_q);
  assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_inj && !arm_wr && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  assert_cnt_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arm_wr |=> cnt_q == '0);
  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_inj && !cfg_we) |=> ($stable(armed_q) && $stable(cnt_q)));
endmodule

// File: rtl/ecc_inj_flip.sv
module ecc_inj_flip #(
  parameter int CHK_W = 8
) (
  input  logic [CHK_W-1:0] chk_in,
  input  logic             par_in,
  input  logic [CHK_W-1:0] mask,
  input  logic [1:0]       half,
  input  logic             do_ecc,
  input  logic             do_par,
  input  logic             fire,
  output logic [CHK_W-1:0] chk_out,
  output logic             par_out
);
  localparam int HALF_W = CHK_W / 2;

  logic [CHK_W-1:0] sel;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign sel[h*HALF_W +: HALF_W] = {HALF_W{half[h]}};
  end

  assign chk_out = chk_in ^ ((fire && do_ecc) ? (mask & sel) : '0);
  assign par_out = par_in ^ (fire && do_par);
endmodule

// File: rtl/ecc_inj_unit.sv
module ecc_inj_unit import ecc_inj_pkg::*; #(
  parameter int DIMM_W = 1,
  parameter int RANK_W = 2,
  parameter int CHAN_W = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 12,
  parameter int COL_W  = 10,
  parameter int CHK_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DIMM_W-1:0] in_dimm,
  input  logic [RANK_W-1:0] in_rank,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [PAGE_W-1:0] in_page,
  input  logic [COL_W-1:0]  in_col,
  input  logic [CHK_W-1:0]  in_chk,
  input  logic              in_par,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHK_W-1:0]  out_chk,
  output logic              out_par,
  output logic              out_injected
);
  localparam int MAX_W = max_of(max_of(max_of(DIMM_W, RANK_W), max_of(CHAN_W, BANK_W)),
                                max_of(PAGE_W, COL_W));

  logic [MAX_W-1:0]      fval  [NUM_FIELDS];
  logic [MAX_W-1:0]      req_f [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fwild;
  logic [NUM_FIELDS-1:0] fhit;
  logic [CHK_W-1:0]      mask;
  logic [1:0]            half;
  kind_t                 kind;
  logic                  armed;
  logic                  fire;
  logic                  xfer_inj;

  assign req_f[0] = MAX_W'(in_dimm);
  assign req_f[1] = MAX_W'(in_rank);
  assign req_f[2] = MAX_W'(in_chan);
  assign req_f[3] = MAX_W'(in_bank);
  assign req_f[4] = MAX_W'(in_page);
  assign req_f[5] = MAX_W'(in_col);

  ecc_inj_cfg #(
    .MAX_W(MAX_W), .FW0(DIMM_W), .FW1(RANK_W), .FW2(CHAN_W),
    .FW3(BANK_W), .FW4(PAGE_W), .FW5(COL_W), .CHK_W(CHK_W), .CNT_W(CNT_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xfer_inj(xfer_inj),
    .fval(fval), .fwild(fwild), .mask(mask), .half(half), .kind(kind), .armed(armed)
  );

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    ecc_inj_field_cmp #(.W(MAX_W)) u_cmp (
      .want(fval[i]), .wild(fwild[i]), .got(req_f[i]), .hit(fhit[i])
    );
  end

  assign fire     = in_valid && armed && (kind.ecc || kind.par) && (&fhit);
  assign xfer_inj = fire && out_ready;

  ecc_inj_flip #(.CHK_W(CHK_W)) u_flip (
    .chk_in(in_chk), .par_in(in_par), .mask(mask), .half(half),
    .do_ecc(kind.ecc), .do_par(kind.par), .fire(fire),
    .chk_out(out_chk), .par_out(out_par)
  );

  assign out_valid    = in_valid;
  assign in_ready     = out_ready;
  assign out_injected = fire;

  assert_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !out_injected) |-> (out_chk == in_chk && out_par == in_par));
  assert_par_keeps_chk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_injected && !kind.ecc) |-> out_chk == in_chk);
  assert_par_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_injected && kind.par) |-> out_par != in_par);
  assert_needs_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_injected |-> (fwild[3] || in_bank == BANK_W'(fval[3])));
endmodule

// File: tb/ecc_inj_unit_tb.sv
module ecc_inj_unit_tb;
  localparam int DIMM_W = 1, RANK_W = 2, CHAN_W = 2, BANK_W = 3;
  localparam int PAGE_W = 12, COL_W = 10, CHK_W = 8, CNT_W = 3;
  localparam int FWB [6] = '{DIMM_W, RANK_W, CHAN_W, BANK_W, PAGE_W, COL_W};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_we;
  logic [3:0] cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic in_valid, in_ready, out_valid, out_ready, in_par, out_par, out_injected;
  logic [DIMM_W-1:0] in_dimm;
  logic [RANK_W-1:0] in_rank;
  logic [CHAN_W-1:0] in_chan;
  logic [BANK_W-1:0] in_bank;
  logic [PAGE_W-1:0] in_page;
  logic [COL_W-1:0]  in_col;
  logic [CHK_W-1:0]  in_chk, out_chk;

  ecc_inj_unit #(.DIMM_W(DIMM_W), .RANK_W(RANK_W), .CHAN_W(CHAN_W), .BANK_W(BANK_W),
    .PAGE_W(PAGE_W), .COL_W(COL_W), .CHK_W(CHK_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .in_valid(in_valid), .in_ready(in_ready), .in_dimm(in_dimm),
    .in_rank(in_rank), .in_chan(in_chan), .in_bank(in_bank), .in_page(in_page),
    .in_col(in_col), .in_chk(in_chk), .in_par(in_par), .out_valid(out_valid),
    .out_ready(out_ready), .out_chk(out_chk), .out_par(out_par), .out_injected(out_injected));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  int unsigned m_val [6];
  bit m_wild [6];
  logic [CHK_W-1:0] m_mask;
  logic [1:0] m_half;
  logic [2:0] m_kind;
  bit m_arm;
  int m_cnt;

  // scoreboard
  logic [CHK_W-1:0] q_chk [$];
  logic q_par [$];
  logic q_inj [$];
  string q_tag [$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (q_chk.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R6 unexpected transfer actual=%h expected=none", out_chk);
      end else begin
        string t;
        t = q_tag.pop_front();
        check({t, " chk"}, 32'(out_chk), 32'(q_chk.pop_front()));
        check({t, " par"}, 32'(out_par), 32'(q_par.pop_front()));
        check({t, " injected"}, 32'(out_injected), 32'(q_inj.pop_front()));
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (a < 4'd6) begin
      m_val[a]  = d & ((32'd1 << FWB[a]) - 1);
      m_wild[a] = d[31];
    end else if (a == 4'd6) m_mask = d[CHK_W-1:0];
    else if (a == 4'd7) m_half = d[1:0];
    else if (a == 4'd8) m_kind = d[2:0];
    else if (a == 4'd9) begin m_arm = (d != 0); m_cnt = 0; end
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [31:0] exp);
    cfg_addr = a;
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic send(string tag, int d, int r, int c, int b, int p, int col,
                      logic [CHK_W-1:0] chk, logic par, int stall);
    int unsigned f [6];
    bit hit;
    logic [CHK_W-1:0] sel;
    @(posedge clk); #1;
    in_dimm = d[DIMM_W-1:0]; in_rank = r[RANK_W-1:0]; in_chan = c[CHAN_W-1:0];
    in_bank = b[BANK_W-1:0]; in_page = p[PAGE_W-1:0]; in_col = col[COL_W-1:0];
    in_chk = chk; in_par = par; in_valid = 1'b1;
    for (int s = 0; s < stall; s++) begin
      out_ready = 1'b0;
      @(posedge clk); #1;
    end
    out_ready = 1'b1;
    f = '{d, r, c, b, p, col};
    hit = m_arm && (m_kind[1] || m_kind[2]);
    for (int i = 0; i < 6; i++) if (!m_wild[i] && m_val[i] != f[i]) hit = 0;
    sel = {{(CHK_W/2){m_half[1]}}, {(CHK_W/2){m_half[0]}}};
    q_chk.push_back(chk ^ ((hit && m_kind[1]) ? (m_mask & sel) : '0));
    q_par.push_back(par ^ (hit && m_kind[2]));
    q_inj.push_back(hit);
    q_tag.push_back(tag);
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (hit) begin
      if (!m_kind[0]) m_arm = 0;
      if (m_cnt < 7) m_cnt++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    in_valid = 0; out_ready = 1; in_dimm = 0; in_rank = 0; in_chan = 0;
    in_bank = 0; in_page = 0; in_col = 0; in_chk = 0; in_par = 0;
    for (int i = 0; i < 6; i++) begin m_val[i] = 0; m_wild[i] = 1; end
    m_mask = 0; m_half = 0; m_kind = 0; m_arm = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 6; a++) rd("R1 match reset", 4'(a), 32'h8000_0000);
    for (int a = 6; a < 11; a++) rd("R1 reg reset", 4'(a), 32'h0);
    send("R6 disarmed passthru", 0, 1, 2, 3, 4, 5, 8'hA5, 1'b0, 0);

    // R4 half selection, R8 one-shot
    wr(4'd6, 32'h5A); wr(4'd7, 32'd1); wr(4'd8, 32'd2); wr(4'd9, 32'd1);
    send("R4 lower half", 0, 0, 0, 0, 0, 0, 8'h00, 1'b0, 0);
    rd("R8 oneshot disarmed", 4'd9, 32'd0);
    rd("R10 count one", 4'd10, 32'd1);
    send("R8 second write clean", 0, 0, 0, 0, 0, 0, 8'h00, 1'b0, 0);
    wr(4'd7, 32'd2); wr(4'd9, 32'd1);
    send("R4 upper half", 1, 1, 1, 1, 1, 1, 8'h0F, 1'b1, 0);
    wr(4'd7, 32'd3); wr(4'd9, 32'h100);
    rd("R7 nonzero arms", 4'd9, 32'd1);
    send("R4 both halves", 0, 3, 3, 7, 9, 9, 8'hFF, 1'b0, 0);

    // R3 matching, R9 repeat, R7 disarm
    wr(4'd8, 32'd3); wr(4'd3, 32'd5); wr(4'd1, 32'd2); wr(4'd9, 32'd1);
    send("R3 match hit", 0, 2, 0, 5, 0, 0, 8'h11, 1'b0, 0);
    send("R3 bank miss", 0, 2, 0, 4, 0, 0, 8'h11, 1'b0, 0);
    send("R3 rank miss", 0, 1, 0, 5, 0, 0, 8'h11, 1'b0, 0);
    send("R9 repeat hit wildcards", 1, 2, 3, 5, 12'hABC, 10'h3FF, 8'h22, 1'b1, 0);
    rd("R9 still armed", 4'd9, 32'd1);
    wr(4'd9, 32'd0);
    send("R7 disarmed passthru", 0, 2, 0, 5, 0, 0, 8'h33, 1'b0, 0);

    // R2 readback
    wr(4'd0, 32'h0000_0003);
    rd("R2 dimm truncated", 4'd0, 32'h0000_0001);
    wr(4'd0, 32'h8000_0000);
    wr(4'd4, 32'h8000_0FFF);
    rd("R2 page readback", 4'd4, 32'h8000_0FFF);
    rd("R2 mask readback", 4'd6, 32'h5A);
    rd("R2 kind readback", 4'd8, 32'd3);
    rd("R2 unmapped", 4'hF, 32'd0);

    // R3 single field miss on page
    wr(4'd3, 32'h8000_0000); wr(4'd1, 32'h8000_0000);
    wr(4'd4, 32'h123); wr(4'd8, 32'd2); wr(4'd9, 32'd1);
    send("R3 page miss", 0, 0, 0, 0, 12'h124, 0, 8'h00, 1'b0, 0);
    send("R3 page hit", 0, 0, 0, 0, 12'h123, 0, 8'h00, 1'b0, 0);
    wr(4'd4, 32'h8000_0000);

    // R5 parity only
    wr(4'd8, 32'd5); wr(4'd9, 32'd1);
    send("R5 parity flip 0", 0, 0, 0, 0, 0, 0, 8'h33, 1'b0, 0);
    send("R5 parity flip 1", 0, 0, 0, 0, 0, 0, 8'h33, 1'b1, 0);

    // R11 stall
    wr(4'd8, 32'd2); wr(4'd9, 32'd1);
    send("R11 stalled oneshot", 0, 0, 0, 0, 0, 0, 8'h00, 1'b0, 2);
    rd("R11 count after stall", 4'd10, 32'd1);
    rd("R11 disarmed once", 4'd9, 32'd0);

    // R10 saturation and clear
    wr(4'd8, 32'd3); wr(4'd9, 32'd1);
    for (int k = 0; k < 9; k++) send("R10 repeat burst", 0, 0, 0, 0, k, 0, 8'(k), 1'b0, 0);
    rd("R10 saturated", 4'd10, 32'd7);
    wr(4'd9, 32'd1);
    rd("R10 cleared by arm write", 4'd10, 32'd0);

    // R3 kind without flip bits
    wr(4'd8, 32'd0); wr(4'd9, 32'd1);
    send("R3 kind zero no inject", 0, 0, 0, 0, 0, 0, 8'h77, 1'b1, 0);

    repeat (3) @(posedge clk);
    check("R6 scoreboard drained", 32'(q_chk.size()), 32'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule